// File: doc/BRIEF.md
# Signal-Bus Trigger and Pattern Injector

This block sits between a flash memory controller and the flash pins. It lets an experimenter take over chosen pin lines at a precise moment. It watches the observed flash signal bus and steps through a fixed sequence:

1. Wait for a first masked match.
2. Optionally wait for a second masked match.
3. Count down a programmed delay.
4. Replay a multi-cycle pattern from two FIFOs.

One FIFO holds the data pattern and the other holds a per-line drive mask. On a line whose mask bit is set, the pattern bit reaches the pin and the pin is driven as an output. On every other line, the controller's data and output-enable pass through untouched.

Control and status are plain pins:
- Control inputs are single-cycle pulses: start, force, soft reset and flush.
- Trigger, mask and delay values are level inputs.
- Status outputs give the state code and the FIFO empty and full flags.

Both FIFOs are filled through valid/ready push ports. An entry is taken on a rising clock edge where both valid and ready are high. Ready is low exactly while that FIFO is full. While ready is low, the source must hold its data, because the entry is not taken. A push in the same cycle as a flush is discarded. The pin tri-state buffers and any bus bridge are outside the block.

Top module: `sig_inject_top`

## Requirements
- R1: After reset the state code is 0 (idle), both FIFOs report empty and not full, and the pins carry the controller's data and output-enable unchanged.
- R2: A start pulse in idle moves the state to code 1 (first trigger wait) on the next edge. A start pulse in any other state is ignored.
- R3: In state 1 the block advances at an edge where the monitored bus equals the first trigger value on every bit whose first-mask bit is 1. Bits whose mask bit is 0 do not take part in the comparison.
- R4: A first-trigger match leads to state code 2 (second trigger wait) when the second mask is nonzero, and straight to code 3 (delay) when it is all zeros. State 2 moves to code 3 on a second masked match.
- R5: A force pulse in state 1 or state 2 moves the state to code 3 on the next edge, whether or not the bus matches.
- R6: Entering state 3 loads a 32-bit counter with the delay value. The state stays 3 for delay+1 cycles and then becomes code 4 (drive). A delay of 0 gives exactly one cycle in state 3.
- R7: In state 4, one entry is taken from each FIFO per cycle while both FIFOs hold data. For each line i, a drive-mask bit of 1 puts pattern bit i on pin data with pin output-enable 1. A drive-mask bit of 0 passes the controller's data and output-enable bit i.
- R8: State 4 returns to code 0 on the edge that takes the last entry of either FIFO, or on the first edge if a FIFO is already empty. N loaded entries therefore give N override cycles.
- R9: In every state other than 4, pin data and output-enable equal the controller's, whatever the FIFOs hold.
- R10: A push port is ready exactly when its FIFO is not full. The full flag is 1 once DEPTH entries are stored.
- R11: A flush pulse empties both FIFOs by the next edge.
- R12: A soft-reset pulse returns the state to code 0 from any state, with priority over start, force and matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Start pulse, idle to first trigger wait |
| cfg_force | input | 1 | Force pulse, trigger wait to delay |
| cfg_soft_rst | input | 1 | Return sequence to idle |
| cfg_flush | input | 1 | Empty both FIFOs |
| trig1_value | input | W | First trigger compare value |
| trig1_mask | input | W | First trigger compare mask |
| trig2_value | input | W | Second trigger compare value |
| trig2_mask | input | W | Second trigger mask, zero skips the stage |
| delay_value | input | DW | Delay count loaded on entering delay |
| mon_bus | input | W | Observed flash signal bus |
| ctl_dout | input | W | Controller pin data |
| ctl_oe | input | W | Controller pin output-enable |
| pat_valid | input | 1 | Pattern push valid |
| pat_data | input | W | Pattern push data |
| pat_ready | output | 1 | Pattern FIFO can accept |
| dmk_valid | input | 1 | Drive-mask push valid |
| dmk_data | input | W | Drive-mask push data |
| dmk_ready | output | 1 | Drive-mask FIFO can accept |
| pin_dout | output | W | Data toward the pin buffers |
| pin_oe | output | W | Output-enable toward the pin buffers |
| stat_state | output | 3 | State code 0..4 |
| stat_pat_empty | output | 1 | Pattern FIFO empty |
| stat_pat_full | output | 1 | Pattern FIFO full |
| stat_dmk_empty | output | 1 | Drive-mask FIFO empty |
| stat_dmk_full | output | 1 | Drive-mask FIFO full |

## Verification
The hardest situation to reach is the exact timing at the end of the delay and the start of the override. Both depend on the delay-entry load, the countdown and the FIFO head all lining up on the same edges. The stimulus loads both FIFOs first and then uses the force pulse to enter the delay state at a known cycle. It counts the cycles spent in state 3 for delays of 0 and 3, and then checks the pins cycle by cycle through every replayed entry until the return to idle. The masked comparison is covered by a table of bus, value and mask vectors that includes a fully masked trigger and mismatches confined to masked-out bits.

// File: rtl/inj_pkg.sv
package inj_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM1  = 3'd1,
    ST_ARM2  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_DRIVE = 3'd4
  } inj_state_e;
endpackage

// File: rtl/inj_fifo.sv
module inj_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         last
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign last     = (count == CW'(1));
  assign in_ready = ~full;
  assign push_ok  = in_valid & in_ready & ~flush;
  assign pop_ok   = pop & ~empty & ~flush;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      if (push_ok && !pop_ok)      count <= count + CW'(1);
      else if (pop_ok && !push_ok) count <= count - CW'(1);
    end
  end

  AST_FIFO_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !full && !pop && !flush) |=> count == $past(count) + CW'(1)); // R10
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R11
endmodule

// File: rtl/inj_seq.sv
module inj_seq
  import inj_pkg::*;
#(
  parameter int W  = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          force_trig,
  input  logic          soft_rst,
  input  logic [W-1:0]  mon,
  input  logic [W-1:0]  t1_val,
  input  logic [W-1:0]  t1_mask,
  input  logic [W-1:0]  t2_val,
  input  logic [W-1:0]  t2_mask,
  input  logic [DW-1:0] delay_val,
  input  logic          pat_empty,
  input  logic          dmk_empty,
  input  logic          pat_last,
  input  logic          dmk_last,
  output inj_state_e    state,
  output logic          pop
);
  inj_state_e    nxt;
  logic [DW-1:0] cnt;
  logic          hit1, hit2, load;

  assign hit1 = (((mon ^ t1_val) & t1_mask) == '0);
  assign hit2 = (((mon ^ t2_val) & t2_mask) == '0);
  assign pop  = (state == ST_DRIVE) && !pat_empty && !dmk_empty;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start) nxt = ST_ARM1;
      ST_ARM1: begin
        if (force_trig)  nxt = ST_HOLD;
        else if (hit1)   nxt = (t2_mask == '0) ? ST_HOLD : ST_ARM2;
      end
      ST_ARM2:  if (force_trig || hit2) nxt = ST_HOLD;
      ST_HOLD:  if (cnt == '0) nxt = ST_DRIVE;
      ST_DRIVE: if (!pop || pat_last || dmk_last) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
    if (soft_rst) nxt = ST_IDLE;
  end

  assign load = (nxt == ST_HOLD) && (state != ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (load)                           cnt <= delay_val;
      else if (state == ST_HOLD && cnt != '0) cnt <= cnt - DW'(1);
    end
  end

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && !soft_rst) |=> state == ST_ARM1); // R2
  AST_SKIP_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARM1 && hit1 && t2_mask == '0 && !soft_rst) |=> state == ST_HOLD); // R4
  AST_FORCE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ARM1 || state == ST_ARM2) && force_trig && !soft_rst) |=> state == ST_HOLD); // R5
  AST_DELAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && cnt != '0 && !soft_rst) |=> (state == ST_HOLD && cnt == $past(cnt) - DW'(1))); // R6
  AST_DRIVE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRIVE && !pop) |=> state == ST_IDLE); // R8
  AST_SOFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> state == ST_IDLE); // R12
endmodule

// File: rtl/inj_mux.sv
module inj_mux #(
  parameter int W = 8
) (
  input  logic         active,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] pat,
  input  logic [W-1:0] ctl_dout,
  input  logic [W-1:0] ctl_oe,
  output logic [W-1:0] pin_dout,
  output logic [W-1:0] pin_oe
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic take;
    assign take        = active & sel[i];
    assign pin_dout[i] = take ? pat[i] : ctl_dout[i];
    assign pin_oe[i]   = take ? 1'b1   : ctl_oe[i];
  end
endmodule

// File: rtl/sig_inject_top.sv
module sig_inject_top
  import inj_pkg::*;
#(
  parameter int W     = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic          cfg_force,
  input  logic          cfg_soft_rst,
  input  logic          cfg_flush,
  input  logic [W-1:0]  trig1_value,
  input  logic [W-1:0]  trig1_mask,
  input  logic [W-1:0]  trig2_value,
  input  logic [W-1:0]  trig2_mask,
  input  logic [DW-1:0] delay_value,
  input  logic [W-1:0]  mon_bus,
  input  logic [W-1:0]  ctl_dout,
  input  logic [W-1:0]  ctl_oe,
  input  logic          pat_valid,
  input  logic [W-1:0]  pat_data,
  output logic          pat_ready,
  input  logic          dmk_valid,
  input  logic [W-1:0]  dmk_data,
  output logic          dmk_ready,
  output logic [W-1:0]  pin_dout,
  output logic [W-1:0]  pin_oe,
  output logic [2:0]    stat_state,
  output logic          stat_pat_empty,
  output logic          stat_pat_full,
  output logic          stat_dmk_empty,
  output logic          stat_dmk_full
);
  inj_state_e   state;
  logic         pop, pat_last, dmk_last;
  logic [W-1:0] pat_head, dmk_head;

  inj_fifo #(.W(W), .DEPTH(DEPTH)) u_pat (
    .clk(clk), .rst_n(rst_n), .flush(cfg_flush),
    .in_valid(pat_valid), .in_data(pat_data), .in_ready(pat_ready),
    .pop(pop), .head(pat_head), .empty(stat_pat_empty), .full(stat_pat_full),
    .last(pat_last)
  );

  inj_fifo #(.W(W), .DEPTH(DEPTH)) u_dmk (
    .clk(clk), .rst_n(rst_n), .flush(cfg_flush),
    .in_valid(dmk_valid), .in_data(dmk_data), .in_ready(dmk_ready),
    .pop(pop), .head(dmk_head), .empty(stat_dmk_empty), .full(stat_dmk_full),
    .last(dmk_last)
  );

  inj_seq #(.W(W), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(cfg_start), .force_trig(cfg_force),
    .soft_rst(cfg_soft_rst), .mon(mon_bus),
    .t1_val(trig1_value), .t1_mask(trig1_mask),
    .t2_val(trig2_value), .t2_mask(trig2_mask), .delay_val(delay_value),
    .pat_empty(stat_pat_empty), .dmk_empty(stat_dmk_empty),
    .pat_last(pat_last), .dmk_last(dmk_last),
    .state(state), .pop(pop)
  );

  inj_mux #(.W(W)) u_mux (
    .active(pop), .sel(dmk_head), .pat(pat_head),
    .ctl_dout(ctl_dout), .ctl_oe(ctl_oe),
    .pin_dout(pin_dout), .pin_oe(pin_oe)
  );

  assign stat_state = state;

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_DRIVE) |-> (pin_dout == ctl_dout && pin_oe == ctl_oe)); // R9
  AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    pat_ready != stat_pat_full); // R10
endmodule

// File: tb/sig_inject_top_tb_top.sv
`timescale 1ns/1ps
module sig_inject_top_tb_top;
  localparam int W = 8;
  localparam int DW = 32;
  localparam int DEPTH = 8;
  localparam int NV = 6;
  // each vector: {mon, value, mask, expect_advance}
  localparam logic [3*W:0] VEC [NV] = '{
    {8'hA5, 8'hA5, 8'hFF, 1'b1},
    {8'hA4, 8'hA5, 8'hFF, 1'b0},
    {8'hA4, 8'hA5, 8'hFE, 1'b1},
    {8'h00, 8'hFF, 8'h00, 1'b1},
    {8'h3C, 8'h0C, 8'h0F, 1'b1},
    {8'h3C, 8'h0D, 8'h0F, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_start = 0, cfg_force = 0, cfg_soft_rst = 0, cfg_flush = 0;
  logic [W-1:0] trig1_value = '0, trig1_mask = '0, trig2_value = '0, trig2_mask = '0;
  logic [DW-1:0] delay_value = '0;
  logic [W-1:0] mon_bus = '0, ctl_dout = '0, ctl_oe = '0;
  logic pat_valid = 0, dmk_valid = 0;
  logic [W-1:0] pat_data = '0, dmk_data = '0;
  logic pat_ready, dmk_ready;
  logic [W-1:0] pin_dout, pin_oe;
  logic [2:0] stat_state;
  logic stat_pat_empty, stat_pat_full, stat_dmk_empty, stat_dmk_full;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sig_inject_top #(.W(W), .DW(DW), .DEPTH(DEPTH)) dut_i (.*);

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    cfg_start = 1; step(); cfg_start = 0;
  endtask
  task automatic pulse_force();
    cfg_force = 1; step(); cfg_force = 0;
  endtask
  task automatic pulse_soft();
    cfg_soft_rst = 1; step(); cfg_soft_rst = 0;
  endtask

  task automatic push_both(input logic [W-1:0] p, input logic [W-1:0] m);
    pat_valid = 1; pat_data = p; dmk_valid = 1; dmk_data = m;
    step();
    pat_valid = 0; dmk_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    ctl_dout = 8'hA5; ctl_oe = 8'h0F;
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1 state", stat_state, 0);
    chk("R1 empty", {stat_pat_empty, stat_dmk_empty, stat_pat_full, stat_dmk_full}, 4'b1100);
    chk("R1 pin_dout", pin_dout, 8'hA5);
    chk("R1 pin_oe", pin_oe, 8'h0F);

    // R3 masked match table, second mask zero so a match lands in state 3
    trig2_mask = '0;
    for (int i = 0; i < NV; i++) begin
      pulse_soft();
      pulse_start();
      chk("R2 start arms", stat_state, 1);
      mon_bus = VEC[i][3*W:2*W+1];
      trig1_value = VEC[i][2*W:W+1];
      trig1_mask = VEC[i][W:1];
      step();
      chk("R3 masked match", stat_state, VEC[i][0] ? 3 : 1);
    end

    // R4 second trigger, R2 start ignored, R5 force
    pulse_soft();
    delay_value = 32'd100;
    mon_bus = 8'h11; trig1_value = 8'h11; trig1_mask = 8'hFF;
    trig2_value = 8'h22; trig2_mask = 8'hF0;
    pulse_start();
    step();
    chk("R4 enter second wait", stat_state, 2);
    step();
    chk("R4 second wait holds on mismatch", stat_state, 2);
    pulse_start();
    chk("R2 start ignored", stat_state, 2);
    chk("R9 passthrough in wait", pin_dout, 8'hA5);
    pulse_force();
    chk("R5 force from second wait", stat_state, 3);
    pulse_soft();
    chk("R12 soft reset from delay", stat_state, 0);
    pulse_start();
    step();
    mon_bus = 8'h2F;
    step();
    chk("R4 second match", stat_state, 3);
    pulse_soft();
    mon_bus = 8'h00;
    pulse_start();
    pulse_force();
    chk("R5 force from first wait", stat_state, 3);
    pulse_soft();

    // R6 delay length 3 and 0, R8 empty FIFO exit
    for (int d = 0; d < 4; d += 3) begin
      int n;
      delay_value = d;
      pulse_start();
      pulse_force();
      n = 0;
      while (stat_state == 3 && n < 50) begin n++; step(); end
      chk("R6 delay cycles", n, d + 1);
      chk("R6 enters drive", stat_state, 4);
      step();
      chk("R8 empty drive exits", stat_state, 0);
    end

    // R7 R8 pattern replay
    begin
      logic [W-1:0] pv [3];
      logic [W-1:0] mv [3];
      pv = '{8'hF0, 8'h0F, 8'hAA};
      mv = '{8'hFF, 8'h0F, 8'h3C};
      ctl_dout = 8'h55; ctl_oe = 8'h00;
      for (int k = 0; k < 3; k++) push_both(pv[k], mv[k]);
      delay_value = 0;
      pulse_start();
      pulse_force();
      step();
      chk("R7 drive state", stat_state, 4);
      for (int k = 0; k < 3; k++) begin
        chk("R7 pin_dout", pin_dout, (pv[k] & mv[k]) | (8'h55 & ~mv[k]));
        chk("R7 pin_oe", pin_oe, mv[k]);
        step();
      end
      chk("R8 back to idle after N entries", stat_state, 0);
      chk("R9 passthrough after drive", pin_dout, 8'h55);
      chk("R8 fifos drained", {stat_pat_empty, stat_dmk_empty}, 2'b11);
    end

    // R10 full and ready, R11 flush
    chk("R10 ready when not full", pat_ready, 1);
    for (int k = 0; k < DEPTH; k++) begin
      pat_valid = 1; pat_data = k[W-1:0]; step();
    end
    pat_valid = 0;
    chk("R10 full flag", stat_pat_full, 1);
    chk("R10 ready low when full", pat_ready, 0);
    chk("R10 other fifo untouched", stat_dmk_empty, 1);
    cfg_flush = 1; step(); cfg_flush = 0;
    chk("R11 flush empties", {stat_pat_empty, stat_pat_full}, 2'b10);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule